// File: doc/BRIEF.md
# External Bus Idle-State Sequencer

This block runs external bus cycles for a host and can stretch a read by one idle clock, so a slow memory has time to release the shared data lines before the next cycle begins. The host presents a request with an address, a read/write flag and a bus-mode select. The mode select picks either separate address and data lines or a shared, multiplexed address/data bus. Addresses in the external window are split into four equal memory blocks. Each block has its own enable bit that decides whether its reads get the extra idle clock. Write cycles never get one.

A 16-bit control register holds the four enable bits. The host can write it, and it reads back with a fixed pattern in every bit that is not an enable. Requests to internal areas (addresses outside the external window) do not run a bus cycle: they complete after one clock with no bus state and no strobe. While a cycle is in progress the block holds further requests off by keeping its ready output low. All outputs come straight from flops.

Top module: `ext_bus_idle_seq`

## Requirements
- R1: After reset, cfg_rdata reads 0xAAAA, bus_state is 0 (idle), req_ready is 1, and done, addr_strobe, data_strobe and rd_oe are 0.
- R2: cfg_rdata bits 15, 13, 11 and 9 always read 1, and all even bits always read 0, whatever is written to them. Bit 2n+1 (bits 1, 3, 5 and 7) is the enable for memory block n and reads back the last value written to it.
- R3: An address with bit 15 = 1 is external, and bits 14:13 give its memory block (0 to 3). An address with bit 15 = 0 is internal: bus_state stays 0, no strobe rises, and done is 1 for exactly the one clock after acceptance.
- R4: In separate mode (mux_mode = 0), an external cycle shows bus_state 1 (T1), then 2 (T2), then 4 (TI) if an idle clock is inserted. Each state lasts one clock.
- R5: In multiplexed mode (mux_mode = 1), an external cycle shows bus_state 1, 2, 3 (T3), then 4 if an idle clock is inserted.
- R6: A write cycle (req_is_read = 0) never enters bus_state 4, whatever the enable bits are set to.
- R7: An idle clock is inserted on an external read only when the enable bit of that read's memory block is 1.
- R8: done is high for exactly one clock, and that clock is the final state of the cycle (TI when one is inserted).
- R9: req_ready is 1 only in the idle state. A request is taken on a clock edge where req_valid and req_ready are both 1. Once a request is taken, req_ready stays 0 until the clock after done.
- R10: addr_strobe is 1 only in T1. data_strobe is 1 only in T2 and T3. rd_oe is 1 only when data_strobe is 1 during a read. All three are 0 in TI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Request address |
| req_is_read | input | 1 | 1 = read, 0 = write |
| mux_mode | input | 1 | 1 = multiplexed address/data bus, 0 = separate |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register read value |
| bus_state | output | 3 | 0 idle, 1 T1, 2 T2, 3 T3, 4 TI |
| addr_strobe | output | 1 | Address phase strobe |
| data_strobe | output | 1 | Data phase strobe |
| rd_oe | output | 1 | Read data output enable |
| done | output | 1 | Cycle completion pulse |

## Verification
The assertions check on every cycle the local rules of the state sequence: T1 is always followed by T2, TI appears only in reads and is always the cycle's final state, T3 appears only in multiplexed cycles, the bus floats in TI, done lasts one clock, ready is held off after acceptance, and the fixed bits of the control register keep their values. Only the bench scenarios can show that the whole sequence for each mode, direction and block is right: which block the address decodes to, that each enable bit reaches its own block, that internal addresses skip the bus, and that a request held high is taken again right after the previous cycle ends.

// File: rtl/ebis_pkg.sv
package ebis_pkg;
  localparam int CFG_W   = 16;
  localparam int NUM_BLK = 4;
  localparam int BLK_W   = $clog2(NUM_BLK);

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TI   = 3'd4,
    ST_INT  = 3'd5
  } seq_state_e;
endpackage

// File: rtl/ebis_cfg_reg.sv
module ebis_cfg_reg #(
  parameter int W  = 16,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [NB-1:0] blk_en,
  output logic [W-1:0]  rdata
);
  localparam int PAIRS = W / 2;

  function automatic logic [W-1:0] en_mask();
    logic [W-1:0] m = '0;
    for (int i = 0; i < NB; i++) m[2*i+1] = 1'b1;
    return m;
  endfunction
  localparam logic [W-1:0] EN_MASK = en_mask();

  logic wdata_unused;
  assign wdata_unused = ^(wdata & ~EN_MASK);

  // odd bit 2n+1 of the write data feeds block n's enable (R2)
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_en <= '1;
    end else if (we) begin
      for (int i = 0; i < NB; i++) blk_en[i] <= wdata[2*i+1];
    end
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_rd
    assign rdata[2*g] = 1'b0;
    if (g < NB) begin : g_en
      assign rdata[2*g+1] = blk_en[g];
    end else begin : g_fix
      assign rdata[2*g+1] = 1'b1;
    end
  end
endmodule

// File: rtl/ebis_addr_dec.sv
module ebis_addr_dec #(
  parameter int AW    = 16,
  parameter int BLK_W = 2,
  parameter int NB    = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] blk_en,
  output logic          is_ext,
  output logic          idle_en
);
  localparam int LOW_W = AW - 1 - BLK_W;

  logic [BLK_W-1:0] blk;
  logic             addr_unused;

  assign is_ext      = addr[AW-1];
  assign blk         = addr[AW-2 -: BLK_W];
  assign idle_en     = blk_en[blk];
  assign addr_unused = ^addr[LOW_W-1:0];
endmodule

// File: rtl/ebis_seq_fsm.sv
module ebis_seq_fsm
  import ebis_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       is_ext,
  input  logic       is_read,
  input  logic       mux_mode,
  input  logic       idle_en,
  output logic       req_ready,
  output logic [2:0] bus_state,
  output logic       addr_strobe,
  output logic       data_strobe,
  output logic       rd_oe,
  output logic       done
);
  seq_state_e st_q, st_d;
  logic rd_q, mux_q, ins_q;
  logic rd_d, mux_d, ins_d;

  always_comb begin
    st_d  = st_q;
    rd_d  = rd_q;
    mux_d = mux_q;
    ins_d = ins_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        if (is_ext) begin
          st_d  = ST_T1;
          rd_d  = is_read;
          mux_d = mux_mode;
          ins_d = is_read & idle_en;
        end else begin
          st_d  = ST_INT;
        end
      end
      ST_T1:  st_d = ST_T2;
      ST_T2:  st_d = mux_q ? ST_T3 : (ins_q ? ST_TI : ST_IDLE);
      ST_T3:  st_d = ins_q ? ST_TI : ST_IDLE;
      ST_TI:  st_d = ST_IDLE;
      ST_INT: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // outputs are decoded from the next state and held in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      rd_q        <= 1'b0;
      mux_q       <= 1'b0;
      ins_q       <= 1'b0;
      req_ready   <= 1'b1;
      bus_state   <= 3'd0;
      addr_strobe <= 1'b0;
      data_strobe <= 1'b0;
      rd_oe       <= 1'b0;
      done        <= 1'b0;
    end else begin
      st_q        <= st_d;
      rd_q        <= rd_d;
      mux_q       <= mux_d;
      ins_q       <= ins_d;
      req_ready   <= (st_d == ST_IDLE);
      bus_state   <= (st_d == ST_INT) ? 3'd0 : st_d;
      addr_strobe <= (st_d == ST_T1);
      data_strobe <= (st_d == ST_T2) || (st_d == ST_T3);
      rd_oe       <= rd_d && ((st_d == ST_T2) || (st_d == ST_T3));
      done        <= (st_d == ST_INT) || (st_d == ST_TI)
                  || ((st_d == ST_T3) && !ins_d)
                  || ((st_d == ST_T2) && !mux_d && !ins_d);
    end
  end
endmodule

// File: rtl/ext_bus_idle_seq.sv
module ext_bus_idle_seq
  import ebis_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_is_read,
  input  logic             mux_mode,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [2:0]       bus_state,
  output logic             addr_strobe,
  output logic             data_strobe,
  output logic             rd_oe,
  output logic             done
);
  logic [NUM_BLK-1:0] blk_en;
  logic               is_ext;
  logic               idle_en;

  ebis_cfg_reg #(.W(CFG_W), .NB(NUM_BLK)) cfg_i (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .blk_en (blk_en),
    .rdata  (cfg_rdata)
  );

  ebis_addr_dec #(.AW(AW), .BLK_W(BLK_W), .NB(NUM_BLK)) dec_i (
    .addr    (req_addr),
    .blk_en  (blk_en),
    .is_ext  (is_ext),
    .idle_en (idle_en)
  );

  ebis_seq_fsm fsm_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .is_ext      (is_ext),
    .is_read     (req_is_read),
    .mux_mode    (mux_mode),
    .idle_en     (idle_en),
    .req_ready   (req_ready),
    .bus_state   (bus_state),
    .addr_strobe (addr_strobe),
    .data_strobe (data_strobe),
    .rd_oe       (rd_oe),
    .done        (done)
  );
endmodule

// File: rtl/ebis_checker.sv
module ebis_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_is_read,
  input logic        mux_mode,
  input logic [15:0] cfg_rdata,
  input logic [2:0]  bus_state,
  input logic        addr_strobe,
  input logic        data_strobe,
  input logic        rd_oe,
  input logic        done
);
  logic cyc_rd, cyc_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_rd  <= 1'b0;
      cyc_mux <= 1'b0;
    end else if (req_valid && req_ready) begin
      cyc_rd  <= req_is_read;
      cyc_mux <= mux_mode;
    end
  end

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & 16'hFF55) == 16'hAA00);
  p_t1_then_t2_r4: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd1 |=> bus_state == 3'd2);
  p_t3_mux_only_r5: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd3 |-> cyc_mux);
  p_ti_read_only_r6: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd4 |-> cyc_rd);
  p_ti_final_r8: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd4 |-> done);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_state == 3'd0) && !done);
  p_holdoff_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_float_ti_r10: assert property (@(posedge clk) disable iff (rst)
    bus_state == 3'd4 |-> !rd_oe && !data_strobe && !addr_strobe);
  p_oe_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> data_strobe);
endmodule

bind ext_bus_idle_seq ebis_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_is_read (req_is_read),
  .mux_mode    (mux_mode),
  .cfg_rdata   (cfg_rdata),
  .bus_state   (bus_state),
  .addr_strobe (addr_strobe),
  .data_strobe (data_strobe),
  .rd_oe       (rd_oe),
  .done        (done)
);

// File: tb/ext_bus_idle_seq_tb_top.sv
module ext_bus_idle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_is_read = 1'b0;
  logic        mux_mode = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [2:0]  bus_state;
  logic        addr_strobe, data_strobe, rd_oe, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ext_bus_idle_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_is_read(req_is_read), .mux_mode(mux_mode),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_state(bus_state), .addr_strobe(addr_strobe),
    .data_strobe(data_strobe), .rd_oe(rd_oe), .done(done)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic        rd;
    logic        mux;
    logic [2:0]  len;
    logic [14:0] trace;  // state i in bits [3i+2:3i]
  } vec_t;

  // all enables at reset value (every block inserts on reads)
  localparam vec_t VECS [6] = '{
    '{16'h8000, 1'b1, 1'b0, 3'd3, {3'd0, 3'd0, 3'd4, 3'd2, 3'd1}},  // R4 R7
    '{16'h9000, 1'b0, 1'b0, 3'd2, {3'd0, 3'd0, 3'd0, 3'd2, 3'd1}},  // R6
    '{16'hA000, 1'b1, 1'b1, 3'd4, {3'd0, 3'd4, 3'd3, 3'd2, 3'd1}},  // R5
    '{16'hC000, 1'b0, 1'b1, 3'd3, {3'd0, 3'd0, 3'd3, 3'd2, 3'd1}},  // R6
    '{16'h1234, 1'b1, 1'b0, 3'd1, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0}},  // R3
    '{16'hE000, 1'b1, 1'b1, 3'd4, {3'd0, 3'd4, 3'd3, 3'd2, 3'd1}}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_cycle(input vec_t v, input string tag);
    logic [2:0] st;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = v.addr;
    req_is_read = v.rd;
    mux_mode = v.mux;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < int'(v.len); i++) begin
      if (i > 0) @(negedge clk);
      st = v.trace[i*3 +: 3];
      chk({tag, " R4 R5 R3 state"}, bus_state, st);
      chk({tag, " R8 done"}, done, (i == int'(v.len) - 1));
      chk({tag, " R9 ready"}, req_ready, 0);
      chk({tag, " R10 addr_strobe"}, addr_strobe, (st == 3'd1));
      chk({tag, " R10 data_strobe"}, data_strobe, (st == 3'd2 || st == 3'd3));
      chk({tag, " R10 rd_oe"}, rd_oe, v.rd && (st == 3'd2 || st == 3'd3));
    end
    @(negedge clk);
    chk({tag, " R9 ready back"}, req_ready, 1);
    chk({tag, " R8 done low"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg_rdata, 16'hAAAA);
    chk("R1 state", bus_state, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 strobes", {addr_strobe, data_strobe, rd_oe}, 0);

    foreach (VECS[k]) run_cycle(VECS[k], $sformatf("vec%0d", k));

    // R2 fixed bits and enable positions
    cfg_write(16'h0000);
    chk("R2 clear", cfg_rdata, 16'hAA00);
    cfg_write(16'hFFFF);
    chk("R2 set all", cfg_rdata, 16'hAAAA);
    cfg_write(16'h5522);
    chk("R2 blocks 2,0", cfg_rdata, 16'hAA22);

    // R7 per-block enable: blocks 0 and 2 insert, 1 and 3 do not
    v = '{16'hA000, 1'b1, 1'b0, 3'd2, {3'd0, 3'd0, 3'd0, 3'd2, 3'd1}};
    run_cycle(v, "R7 blk1 off sep");
    v = '{16'hC000, 1'b1, 1'b0, 3'd3, {3'd0, 3'd0, 3'd4, 3'd2, 3'd1}};
    run_cycle(v, "R7 blk2 on sep");
    v = '{16'h8000, 1'b1, 1'b1, 3'd4, {3'd0, 3'd4, 3'd3, 3'd2, 3'd1}};
    run_cycle(v, "R7 blk0 on mux");
    v = '{16'hE000, 1'b1, 1'b1, 3'd3, {3'd0, 3'd0, 3'd3, 3'd2, 3'd1}};
    run_cycle(v, "R7 blk3 off mux");
    v = '{16'hC000, 1'b0, 1'b1, 3'd3, {3'd0, 3'd0, 3'd3, 3'd2, 3'd1}};
    run_cycle(v, "R6 blk2 write");

    // R9 held request: taken again right after the cycle ends
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = 16'h9000;
    req_is_read = 1'b0;
    mux_mode = 1'b0;
    @(negedge clk);
    chk("R9 held T1", bus_state, 1);
    chk("R9 held busy", req_ready, 0);
    @(negedge clk);
    chk("R9 held T2", bus_state, 2);
    @(negedge clk);
    chk("R9 idle gap", bus_state, 0);
    chk("R9 ready gap", req_ready, 1);
    @(negedge clk);
    chk("R9 retaken T1", bus_state, 1);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 settle", req_ready, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule